// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast clock by a programmable integer N and emits one single-cycle pulse per N input cycles, for use as the feedback input of a phase detector. The division is built the way a dual-modulus synthesizer loop does it. A prescaler model divides the input clock by either P or P+1. A swallow count A sets how many prescaler periods use the larger modulus. A main count B sets the total number of prescaler periods per output cycle. The result is N = P*B + A, where P is the lower modulus of the selected pair.

A configuration holds a modulus-select bit, A (5 bits) and B (13 bits). It is offered with a load strobe and checked for legality at once. A legal configuration is parked and only takes effect when the output cycle in progress ends, so no output interval ever mixes two ratios. An illegal one raises an error flag and is discarded, so the divider keeps running on its last legal setting. A hold input parks all counters at their load point. On release, counting restarts cleanly from there with the newest legal configuration.

Top module: `swallow_div`

## Requirements
- R1: After reset, div_out and cfg_err are low, and the divider runs with modulus select 0, A = 0 and B = 15, giving a first pulse interval of 240 cycles.
- R2: With a legal configuration active, consecutive div_out pulses are exactly N = P*B + A input cycles apart.
- R3: With LOW_BAND = 0, mod_sel = 0 selects the pair 16/17 (P = 16) and mod_sel = 1 selects 32/33 (P = 32). With LOW_BAND = 1 the pairs are 8/9 and 16/17.
- R4: The boundary settings B = 3, A = B and A = P-1 are legal and divide by exactly P*B + A.
- R5: A legal load takes effect only at the end of the output cycle in progress. That cycle completes with the previous ratio.
- R6: A load strobe with main_in < 3, with swallow_in > main_in, or with swallow_in >= P sets cfg_err one cycle later. The setting is discarded and the ratio is unchanged.
- R7: A legal load strobe clears cfg_err one cycle later. Without a strobe, cfg_err keeps its value.
- R8: While hold is high, no pulse is produced and the counters sit at their load point. The first pulse after release comes N cycles after the first clock edge that sees hold low, using any configuration loaded during the hold.
- R9: Every div_out pulse is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Holds the counters at their load point while high |
| load | input | 1 | One-cycle strobe offering a new configuration |
| mod_sel | input | 1 | Prescaler pair select (see R3) |
| swallow_in | input | 5 | Swallow count A |
| main_in | input | 13 | Main count B |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | Set by an illegal load, cleared by a legal one |

## Verification
A pulse is registered: it appears in the cycle after the N-th counting edge, so pulses are exactly N cycles apart and the first pulse after reset or hold release comes N edges after the first edge that sees the control low. cfg_err settles one edge after the strobe, and a new ratio applies only from the next output interval. The bench drives and samples on the falling edge. It measures each interval in clock periods from the previous pulse, or from the release of reset or hold, against a queue of expected ratios. It offers each new setting only while the final expected interval of the previous setting is in progress, so that interval is checked against the old ratio.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
    localparam int A_W   = 5;
    localparam int B_W   = 13;
    localparam int PC_W  = 6;
    localparam int MIN_B = 3;

    typedef struct packed {
        logic           sel;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } div_cfg_t;

    typedef struct packed {
        logic [PC_W-1:0] pre;
        logic [A_W-1:0]  a_rem;
        logic [B_W-1:0]  b_rem;
        div_cfg_t        act;
        div_cfg_t        pend;
        logic            pend_v;
        logic            err;
        logic            pulse;
    } div_state_t;
endpackage

// File: rtl/swd_modulus.sv
module swd_modulus
    import swallow_div_pkg::*;
#(
    parameter bit LOW_BAND = 1'b0
) (
    input  logic            sel,
    output logic [PC_W-1:0] p_low
);
    generate
        if (LOW_BAND) begin : g_low
            assign p_low = sel ? PC_W'(16) : PC_W'(8);
        end else begin : g_high
            assign p_low = sel ? PC_W'(32) : PC_W'(16);
        end
    endgenerate
endmodule

// File: rtl/swd_legal.sv
module swd_legal
    import swallow_div_pkg::*;
(
    input  logic [A_W-1:0]  a,
    input  logic [B_W-1:0]  b,
    input  logic [PC_W-1:0] p_low,
    output logic            ok
);
    logic [B_W-1:0] a_x, p_x;

    assign a_x = B_W'(a);
    assign p_x = B_W'(p_low);
    // B floor, swallow not above main count, swallow below low modulus
    assign ok  = (b >= B_W'(MIN_B)) && (a_x <= b) && (a_x < p_x);
endmodule

// File: rtl/swallow_div.sv
module swallow_div
    import swallow_div_pkg::*;
#(
    parameter bit          LOW_BAND = 1'b0,
    parameter int unsigned RST_B    = 15,
    parameter bit          RST_SEL  = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           load,
    input  logic           mod_sel,
    input  logic [A_W-1:0] swallow_in,
    input  logic [B_W-1:0] main_in,
    output logic           div_out,
    output logic           cfg_err
);
    localparam logic [PC_W-1:0] RST_P =
        PC_W'(LOW_BAND ? (RST_SEL ? 16 : 8) : (RST_SEL ? 32 : 16));
    localparam div_cfg_t RST_CFG = '{sel: RST_SEL, a: '0, b: B_W'(RST_B)};
    localparam div_state_t RST_STATE = '{
        pre:    RST_P - PC_W'(1),
        a_rem:  '0,
        b_rem:  B_W'(RST_B),
        act:    RST_CFG,
        pend:   RST_CFG,
        pend_v: 1'b0,
        err:    1'b0,
        pulse:  1'b0
    };

    div_state_t      st_q, st_d;
    div_cfg_t        cfg_in, cfg_nxt;
    logic [PC_W-1:0] p_act, p_nxt, p_in;
    logic [A_W-1:0]  a_dec;
    logic            in_ok, cyc_end;

    assign cfg_in  = '{sel: mod_sel, a: swallow_in, b: main_in};
    assign cfg_nxt = st_q.pend_v ? st_q.pend : st_q.act;

    swd_modulus #(.LOW_BAND(LOW_BAND)) u_mod_act (.sel(st_q.act.sel), .p_low(p_act));
    swd_modulus #(.LOW_BAND(LOW_BAND)) u_mod_nxt (.sel(cfg_nxt.sel),  .p_low(p_nxt));
    swd_modulus #(.LOW_BAND(LOW_BAND)) u_mod_in  (.sel(mod_sel),      .p_low(p_in));

    swd_legal u_legal (
        .a     (swallow_in),
        .b     (main_in),
        .p_low (p_in),
        .ok    (in_ok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        a_dec      = (st_q.a_rem != '0) ? st_q.a_rem - A_W'(1) : '0;
        cyc_end    = (st_q.pre == '0) && (st_q.b_rem == B_W'(1));

        if (hold || cyc_end) begin
            // load point: adopt the parked configuration and restart
            st_d.pulse  = !hold;
            st_d.act    = cfg_nxt;
            st_d.pend_v = 1'b0;
            st_d.a_rem  = cfg_nxt.a;
            st_d.b_rem  = cfg_nxt.b;
            st_d.pre    = (cfg_nxt.a != '0) ? p_nxt : p_nxt - PC_W'(1);
        end else if (st_q.pre == '0) begin
            // one prescaler period done: swallow first, then plain modulus
            st_d.a_rem = a_dec;
            st_d.b_rem = st_q.b_rem - B_W'(1);
            st_d.pre   = (a_dec != '0) ? p_act : p_act - PC_W'(1);
        end else begin
            st_d.pre = st_q.pre - PC_W'(1);
        end

        if (load) begin
            if (in_ok) begin
                st_d.pend   = cfg_in;
                st_d.pend_v = 1'b1;
                st_d.err    = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_out = st_q.pulse;
    assign cfg_err = st_q.err;
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk
    import swallow_div_pkg::*;
#(
    parameter bit LOW_BAND = 1'b0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold,
    input logic           load,
    input logic           mod_sel,
    input logic [A_W-1:0] swallow_in,
    input logic [B_W-1:0] main_in,
    input logic           div_out,
    input logic           cfg_err
);
    logic [B_W-1:0] p_chk;
    logic           legal_chk;

    assign p_chk = LOW_BAND ? (mod_sel ? B_W'(16) : B_W'(8))
                            : (mod_sel ? B_W'(32) : B_W'(16));
    assign legal_chk = (main_in >= B_W'(3)) &&
                       (B_W'(swallow_in) <= main_in) &&
                       (B_W'(swallow_in) < p_chk);

    assert_one_cycle_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    assert_quiet_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !div_out);

    assert_flag_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !legal_chk) |=> cfg_err);

    assert_clear_on_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && legal_chk) |=> !cfg_err);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));
endmodule

bind swallow_div swallow_div_chk #(.LOW_BAND(LOW_BAND)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .load       (load),
    .mod_sel    (mod_sel),
    .swallow_in (swallow_in),
    .main_in    (main_in),
    .div_out    (div_out),
    .cfg_err    (cfg_err)
);

// File: tb/tb_swallow_div.sv
module tb_swallow_div;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic        load = 1'b0;
    logic        mod_sel = 1'b0;
    logic [4:0]  swallow_in = '0;
    logic [12:0] main_in = '0;
    logic        div_out;
    logic        cfg_err;

    int    n_checks = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    time   last_t = 0;
    bit    in_hold = 1'b0;
    bit    mon_on = 1'b0;

    swallow_div dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .load       (load),
        .mod_sel    (mod_sel),
        .swallow_in (swallow_in),
        .main_in    (main_in),
        .div_out    (div_out),
        .cfg_err    (cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act,
                         input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int p_of(input bit s);
        return s ? 32 : 16;
    endfunction

    task automatic push(input int n, input int k, input string tag);
        for (int i = 0; i < k; i++) begin
            exp_q.push_back(n);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wait_tail();
        do @(negedge clk); while (exp_q.size() > 1);
    endtask

    task automatic strobe(input bit s, input int a, input int b);
        mod_sel    = s;
        swallow_in = 5'(a);
        main_in    = 13'(b);
        load       = 1'b1;
        @(negedge clk);
        load       = 1'b0;
    endtask

    // monitor: interval between pulses against the expected queue
    always @(negedge clk) begin
        if (mon_on && div_out) begin
            if (in_hold) begin
                check(1'b0, "R8", 1, 0, "pulse while hold high");
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R2", 1, 0, "unexpected pulse");
            end else begin
                int    gap;
                int    n;
                string t;
                gap = int'(($time - last_t) / CLK_PERIOD);
                n   = exp_q.pop_front();
                t   = tag_q.pop_front();
                check(gap == n, t, gap, n, "pulse interval");
            end
            last_t = $time;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2", 0, 1, "watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R1", int'(div_out), 0, "div_out in reset");
        check(cfg_err == 1'b0, "R1", int'(cfg_err), 0, "cfg_err in reset");
        push(240, 2, "R1");
        mon_on = 1'b1;
        rst_n  = 1'b1;
        last_t = $time;

        // R5: new ratio only after the interval in progress
        wait_tail();
        strobe(1'b0, 5, 20);
        check(cfg_err == 1'b0, "R7", int'(cfg_err), 0, "legal load");
        push(16*20 + 5, 3, "R5");

        // R3: upper pair
        wait_tail();
        strobe(1'b1, 7, 10);
        push(32*10 + 7, 3, "R3");

        // R4 boundaries
        wait_tail();
        strobe(1'b1, 31, 40);
        push(32*40 + 31, 2, "R4");
        wait_tail();
        strobe(1'b0, 0, 3);
        push(16*3, 3, "R4");
        wait_tail();
        strobe(1'b0, 15, 15);
        push(16*15 + 15, 3, "R4");

        // R6: illegal settings flagged and discarded
        wait_tail();
        strobe(1'b0, 0, 2);
        check(cfg_err == 1'b1, "R6", int'(cfg_err), 1, "B below 3");
        strobe(1'b0, 9, 5);
        check(cfg_err == 1'b1, "R6", int'(cfg_err), 1, "A above B");
        strobe(1'b0, 16, 40);
        check(cfg_err == 1'b1, "R6", int'(cfg_err), 1, "A not below P");
        repeat (5) @(negedge clk);
        check(cfg_err == 1'b1, "R7", int'(cfg_err), 1, "flag holds without strobe");
        push(16*15 + 15, 2, "R6");

        wait_tail();
        strobe(1'b1, 3, 12);
        check(cfg_err == 1'b0, "R7", int'(cfg_err), 0, "legal load clears flag");
        push(32*12 + 3, 2, "R7");

        // R8: hold parks the counters, load during hold used on release
        wait_tail();
        @(negedge clk);
        hold    = 1'b1;
        in_hold = 1'b1;
        exp_q.delete();
        tag_q.delete();
        strobe(1'b0, 3, 6);
        repeat (150) @(negedge clk);
        check(div_out == 1'b0, "R8", int'(div_out), 0, "quiet in hold");
        push(16*6 + 3, 3, "R8");
        hold    = 1'b0;
        in_hold = 1'b0;
        last_t  = $time;

        // R2: random legal settings
        for (int i = 0; i < 6; i++) begin
            bit s;
            int p;
            int b;
            int a;
            s = 1'($urandom % 2);
            p = p_of(s);
            b = 3 + int'($urandom % 40);
            a = int'($urandom % (((p - 1) < b ? (p - 1) : b) + 1));
            wait_tail();
            strobe(s, a, b);
            check(cfg_err == 1'b0, "R2", int'(cfg_err), 0, "random legal load");
            push(p*b + a, 2, "R2");
        end

        do @(negedge clk); while (exp_q.size() != 0);
        mon_on = 1'b0;
        hold   = 1'b1;
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule